// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to fifteen interrupt sources, numbered 1 to 15, into a single pending vector and presents the processor with one interrupt level. A rising edge on a source input marks that source as pending. Software can also raise any source by writing ones to a force register, and can drop pending sources by writing ones to a clear register. A mask register selects which pending sources may reach the processor. The output level is the number of the highest-numbered source that is both pending and unmasked. The same number serves as the priority, and it also selects the trap vector, which is the level plus 0x10.

When the processor takes the interrupt, it returns an acknowledge that carries the level it is servicing. That acknowledge drops the matching pending bit. Bit 0 of every register is reserved and never holds state. Software reaches the registers through a simple write port and a combinational read port, using byte offsets 0x90 (mask), 0x94 (pending), 0x98 (force) and 0x9C (clear).

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the mask and pending registers read 0, and both irqLevel and trapType are 0.
- R2: A 0-to-1 transition of srcIn[n] (n from 1 to 15), seen at a clock edge, sets pending bit n at that edge. A source held high does not set the bit again after it has been cleared. The mask has no influence on this latching.
- R3: The mask register at offset 0x90 stores bits 15..1 of a write. It reads back zero-extended to 32 bits. A mask bit of 1 enables its source.
- R4: Offset 0x94 reads the pending register, with source n in bit n. Writes to 0x94 change nothing.
- R5: Writing offset 0x98 sets every pending bit whose data bit is 1 and leaves the other bits unchanged. Offset 0x98 reads as 0.
- R6: Writing offset 0x9C clears every pending bit whose data bit is 1 and leaves the other bits unchanged. Offset 0x9C reads as 0.
- R7: irqLevel equals the highest n for which pending bit n and mask bit n are both 1, or 0 when no such n exists. It reflects the registers as updated at the latest clock edge.
- R8: ackValid with ackLevel n (1..15) clears pending bit n at that clock edge. An acknowledge with level 0 has no effect.
- R9: When a set (a source edge or a force write) and a clear (a clear write or an acknowledge) hit the same bit at the same edge, the bit ends up set.
- R10: srcIn[0] and bit 0 of every write are ignored. Bit 0 of mask and pending always reads 0.
- R11: trapType is 0x10 plus irqLevel when irqLevel is nonzero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 16 | Source request lines; bit n is source n, and bit 0 is ignored |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Byte offset of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| ackLevel | input | 4 | Level being acknowledged |
| irqLevel | output | 4 | Highest pending and unmasked source, or 0 |
| trapType | output | 8 | Trap vector for irqLevel, or 0 |

## Verification
Some properties are checked by the assertions on every cycle. Bit 0 never holds state. The reported level always belongs to a bit that is both pending and unmasked. A set always survives a simultaneous clear. A clear with no competing set takes effect. Pending and mask change only when a strobe allows it. Other behaviour can only be shown by the bench scenarios. These are: edge detection as opposed to level sensing while a source is held high, the choice of the highest active source among several, the register offsets and their read-back values, and the exact trap vector numbers.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic maskWr;
    logic forceWr;
    logic clearWr;
    logic ackHit;
  } irqStrobe_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 15,
  localparam int LVL_W = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:0]  activeVec,
  output logic [LVL_W-1:0]  level
);
  // Scan upward; the last active index found wins, so higher numbers take priority
  always_comb begin
    level = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (activeVec[i]) level = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 8'h90,
  parameter logic [ADDR_W-1:0] FORCE_OFF = 8'h98,
  parameter logic [ADDR_W-1:0] CLEAR_OFF = 8'h9C,
  localparam int LVL_W = $clog2(NUM_SRC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output irqStrobe_t        strb
);
  always_comb begin
    strb.maskWr  = wrEn && (wrAddr == MASK_OFF);
    strb.forceWr = wrEn && (wrAddr == FORCE_OFF);
    strb.clearWr = wrEn && (wrAddr == CLEAR_OFF);
    strb.ackHit  = ackValid && (ackLevel != '0) && (ackLevel <= LVL_W'(NUM_SRC));
  end

  // R3
  write_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.maskWr, strb.forceWr, strb.clearWr}));
endmodule

// File: rtl/irq_ctrl_datapath.sv
module irq_ctrl_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h90,
  parameter logic [ADDR_W-1:0] PEND_OFF = 8'h94,
  localparam int LVL_W = $clog2(NUM_SRC + 1),
  localparam int VEC_W = NUM_SRC + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strb,
  input  logic [VEC_W-1:0]  wrBits,
  input  logic [LVL_W-1:0]  ackLevel,
  input  logic [VEC_W-1:0]  srcIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [LVL_W-1:0]  irqLevel
);
  localparam logic [VEC_W-1:0] LIVE_BITS = {{NUM_SRC{1'b1}}, 1'b0};

  logic [VEC_W-1:0] maskReg, pendReg, prevSrc;
  logic [VEC_W-1:0] riseVec, setVec, clrVec, ackVec;

  assign riseVec = srcIn & ~prevSrc;
  assign ackVec  = strb.ackHit ? (VEC_W'(1) << ackLevel) : '0;
  assign setVec  = (riseVec | (strb.forceWr ? wrBits : '0)) & LIVE_BITS;
  assign clrVec  = (strb.clearWr ? wrBits : '0) | ackVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      pendReg <= '0;
      prevSrc <= '0;
    end else begin
      prevSrc <= srcIn;
      pendReg <= (pendReg & ~clrVec) | setVec;
      if (strb.maskWr) maskReg <= wrBits & LIVE_BITS;
    end
  end

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .activeVec(pendReg & maskReg),
    .level    (irqLevel)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == MASK_OFF)      rdData = DATA_W'(maskReg);
    else if (rdAddr == PEND_OFF) rdData = DATA_W'(pendReg);
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((pendReg & $past(setVec)) == $past(setVec)));
  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & ~setVec) != '0) |=> ((pendReg & $past(clrVec & ~setVec)) == '0));
  // R10
  bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendReg[0] && !maskReg[0]);
  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.maskWr |=> $stable(maskReg));
  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setVec == '0 && clrVec == '0) |=> $stable(pendReg));
  // R7
  level_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> (pendReg[irqLevel] && maskReg[irqLevel]));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int TRAP_W = 8,
  parameter logic [TRAP_W-1:0] TRAP_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 8'h90,
  parameter logic [ADDR_W-1:0] PEND_OFF  = 8'h94,
  parameter logic [ADDR_W-1:0] FORCE_OFF = 8'h98,
  parameter logic [ADDR_W-1:0] CLEAR_OFF = 8'h9C,
  localparam int LVL_W = $clog2(NUM_SRC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC:0]  srcIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output logic [LVL_W-1:0]  irqLevel,
  output logic [TRAP_W-1:0] trapType
);
  irqStrobe_t strb;
  logic unusedWrHi;
  assign unusedWrHi = ^wrData[DATA_W-1:NUM_SRC+1];

  irq_ctrl_decode #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
    .MASK_OFF(MASK_OFF), .FORCE_OFF(FORCE_OFF), .CLEAR_OFF(CLEAR_OFF)
  ) u_dec (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .ackValid(ackValid), .ackLevel(ackLevel), .strb(strb)
  );

  irq_ctrl_datapath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .MASK_OFF(MASK_OFF), .PEND_OFF(PEND_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBits(wrData[NUM_SRC:0]),
    .ackLevel(ackLevel), .srcIn(srcIn), .rdAddr(rdAddr),
    .rdData(rdData), .irqLevel(irqLevel)
  );

  assign trapType = (irqLevel != '0) ? (TRAP_BASE + TRAP_W'(irqLevel)) : '0;

  // R11
  trap_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapType == '0) || (trapType > TRAP_BASE));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic clk = 0, rstN = 0;
  logic [15:0] srcIn = '0;
  logic wrEn = 0, ackValid = 0;
  logic [7:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [3:0] ackLevel = '0, irqLevel;
  logic [7:0] trapType;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { string tag; int kind; logic [31:0] exp; } item_t;
  item_t q[$];

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .ackValid(ackValid),
    .ackLevel(ackLevel), .irqLevel(irqLevel), .trapType(trapType)
  );

  always #5 clk = ~clk;

  // Monitor: compares queued expectations just after each rising edge
  initial forever begin
    @(posedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? {28'b0, irqLevel} : (it.kind == 2) ? {24'b0, trapType} : rdData;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // kind: 0 level, 1 register read, 2 trap vector
  task automatic expect_val(string tag, int kind, logic [7:0] addr, logic [31:0] val);
    item_t it;
    @(negedge clk);
    if (kind == 1) rdAddr = addr;
    it.tag = tag; it.kind = kind; it.exp = val;
    q.push_back(it);
    @(posedge clk); #4;
  endtask

  task automatic do_write(logic [7:0] addr, logic [31:0] data);
    @(negedge clk); wrEn = 1; wrAddr = addr; wrData = data;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); srcIn[n] = 1;
    @(negedge clk); srcIn[n] = 0;
  endtask

  task automatic do_ack(logic [3:0] lvl);
    @(negedge clk); ackValid = 1; ackLevel = lvl;
    @(negedge clk); ackValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    expect_val("R1 level after reset", 0, 0, 0);
    expect_val("R1 mask after reset", 1, 8'h90, 0);
    expect_val("R1 pending after reset", 1, 8'h94, 0);
    expect_val("R11 trap after reset", 2, 0, 0);

    pulse(5);
    expect_val("R2 edge latched while masked", 1, 8'h94, 32'h0020);
    expect_val("R7 masked source gives level 0", 0, 0, 0);

    do_write(8'h90, 32'hFFFF_FFFF);
    expect_val("R3 R10 mask readback", 1, 8'h90, 32'h0000_FFFE);
    expect_val("R7 level after unmask", 0, 0, 5);
    expect_val("R11 trap for level 5", 2, 0, 32'h15);

    do_write(8'h98, 32'h0000_0108);
    expect_val("R5 force sets bits", 1, 8'h94, 32'h0128);
    expect_val("R7 highest wins", 0, 0, 8);
    expect_val("R5 force reads zero", 1, 8'h98, 0);

    do_write(8'h94, 32'h0000_FFFF);
    expect_val("R4 pending write ignored", 1, 8'h94, 32'h0128);

    do_write(8'h9C, 32'h0000_0100);
    expect_val("R6 clear drops bit", 1, 8'h94, 32'h0028);
    expect_val("R6 level after clear", 0, 0, 5);
    expect_val("R6 clear reads zero", 1, 8'h9C, 0);

    do_ack(4'd5);
    expect_val("R8 ack clears level", 1, 8'h94, 32'h0008);
    expect_val("R8 level after ack", 0, 0, 3);
    do_ack(4'd0);
    expect_val("R8 ack level 0 no effect", 1, 8'h94, 32'h0008);

    do_write(8'h90, 32'h0000_0004);
    expect_val("R3 R7 mask hides pending", 0, 0, 0);
    do_write(8'h90, 32'h0000_FFFE);
    expect_val("R7 level restored", 0, 0, 3);

    // Source edge and clear write on the same bit in the same cycle
    @(negedge clk); srcIn[9] = 1; wrEn = 1; wrAddr = 8'h9C; wrData = 32'h0200;
    @(negedge clk); wrEn = 0;
    expect_val("R9 edge beats clear", 1, 8'h94, 32'h0208);
    expect_val("R9 level 9", 0, 0, 9);
    do_write(8'h9C, 32'h0000_0200);
    expect_val("R2 held source not relatched", 1, 8'h94, 32'h0008);
    expect_val("R2 held source still clear", 1, 8'h94, 32'h0008);
    @(negedge clk); srcIn[9] = 0;

    // Force and acknowledge on the same bit in the same cycle
    @(negedge clk); wrEn = 1; wrAddr = 8'h98; wrData = 32'h8000; ackValid = 1; ackLevel = 4'd15;
    @(negedge clk); wrEn = 0; ackValid = 0;
    expect_val("R9 force beats ack", 1, 8'h94, 32'h8008);
    expect_val("R7 level 15", 0, 0, 15);
    expect_val("R11 trap for level 15", 2, 0, 32'h1F);

    pulse(0);
    do_write(8'h98, 32'h0000_0001);
    expect_val("R10 bit 0 never set", 1, 8'h94, 32'h8008);

    do_write(8'h9C, 32'h0000_FFFF);
    expect_val("R6 clear all", 1, 8'h94, 0);
    expect_val("R7 idle level", 0, 0, 0);
    expect_val("R11 idle trap", 2, 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule